// File: doc/BRIEF.md
# Receive IQ DC and Imbalance Conditioner

This block sits between a pair of sampling converters and the downconversion chain. Each clock it may accept one signed in-phase and one quadrature sample, qualified by a valid strobe. It subtracts a programmable DC offset from each rail. It can then cancel gain and phase mismatch by adding scaled copies of both corrected rails into the quadrature rail. The result comes out as a pair of 24-bit samples with a matching strobe, a fixed three clocks later.

The offsets and the two mismatch coefficients are loaded through a small settings port: an 8-bit address, 32-bit data and a write strobe. The build parameter `IMB_EN` selects whether the mismatch stage is present. With `IMB_EN` set to 0, the quadrature rail gets only DC removal and widening, and the latency stays the same. The default width is 16 bits in and 24 bits out. The corrected 17-bit difference is scaled by 2^7, so it fills the output word.

Top module: `rx_iq_conditioner`

## Requirements
- R1: After reset, `out_vld` is 0 and both outputs are 0. All four settings read as 0, so a sample (i,q) comes out as (i·128, q·128).
- R2: `out_vld` is `in_vld` delayed by exactly three rising edges, counting the edge that captures the input. Back-to-back samples produce back-to-back results in order.
- R3: `out_i` = (in_i − dc_i)·128, computed without loss.
- R4: With `IMB_EN`=1, `out_q` = floor(((Qd·2^17) + mag·Id + phase·Qd) / 2^10). Here Id = in_i − dc_i and Qd = in_q − dc_q, and mag and phase are signed 18-bit values with 17 fraction bits.
- R5: If the quadrature result exceeds the 24-bit signed range, it is clamped to 8388607 or −8388608 instead of wrapping.
- R6: A write with `set_stb`=1 loads one setting, selected by address. Address 0x40 loads dc_i from data[15:0]. Address 0x41 loads dc_q from data[15:0]. Address 0x42 loads mag from data[17:0]. Address 0x43 loads phase from data[17:0]. All four fields are signed. A new value applies to samples presented two or more cycles after the write.
- R7: A write to any other address, or address and data presented with `set_stb`=0, changes no setting. This shows at the outputs of later samples.
- R8: While `out_vld` is 0, `out_i` and `out_q` hold their last values.
- R9: With `IMB_EN`=0, `out_q` = (in_q − dc_q)·128, and mag and phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 8 | Settings address |
| set_data | input | 32 | Settings write data |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| in_vld | input | 1 | Input sample pair valid |
| out_i | output | 24 | Corrected in-phase sample, signed |
| out_q | output | 24 | Corrected quadrature sample, signed |
| out_vld | output | 1 | Output sample pair valid |

## Verification
A corrupted offset register shows as a constant error on every result from the next sample onward. A wrong coefficient shows only on the quadrature rail, and only in proportion to the sample values. For that reason the bench drives several sample patterns, including large ones. A slip in the valid pipeline moves the strobe relative to its data and appears three cycles after the offending input. Each result is compared with a model, and every result's arrival cycle is checked. A missing clamp appears as a sign-flipped result the first time an extreme pair is sent. A second instance built without the mismatch stage checks the bypass path against the same stream.

// File: rtl/rxiq_pkg.sv
package rxiq_pkg;
   // Settings register offsets relative to the block base address
   localparam logic [1:0] REG_DC_I  = 2'd0;
   localparam logic [1:0] REG_DC_Q  = 2'd1;
   localparam logic [1:0] REG_MAG   = 2'd2;
   localparam logic [1:0] REG_PHASE = 2'd3;
endpackage

// File: rtl/rxiq_settings.sv
module rxiq_settings #(
   parameter int          IN_W   = 16,
   parameter int          COEF_W = 18,
   parameter logic [7:0]  BASE   = 8'h40
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     set_stb,
   input  logic [7:0]               set_addr,
   input  logic [31:0]              set_data,
   output logic signed [IN_W-1:0]   dc_i,
   output logic signed [IN_W-1:0]   dc_q,
   output logic signed [COEF_W-1:0] mag,
   output logic signed [COEF_W-1:0] phase
);
   import rxiq_pkg::*;

   if (IN_W > 32 || COEF_W > 32) begin : g_bad_width
      $error("rxiq_settings: field wider than settings data");
   end

   logic hit;
   assign hit = set_stb && (set_addr[7:2] == BASE[7:2]);

   always_ff @(posedge clk) begin
      if (rst) begin
         dc_i  <= '0;
         dc_q  <= '0;
         mag   <= '0;
         phase <= '0;
      end else if (hit) begin
         case (set_addr[1:0])
            REG_DC_I:  dc_i  <= set_data[IN_W-1:0];
            REG_DC_Q:  dc_q  <= set_data[IN_W-1:0];
            REG_MAG:   mag   <= set_data[COEF_W-1:0];
            default:   phase <= set_data[COEF_W-1:0];
         endcase
      end
   end

   assert_dc_write_R6: assert property (@(posedge clk) disable iff (rst)
      (set_stb && set_addr == BASE) |=> (dc_i == $past(set_data[IN_W-1:0])));

   assert_no_write_R7: assert property (@(posedge clk) disable iff (rst)
      (!set_stb || set_addr[7:2] != BASE[7:2]) |=>
      ($stable(dc_i) && $stable(dc_q) && $stable(mag) && $stable(phase)));
endmodule

// File: rtl/rxiq_dc_stage.sv
module rxiq_dc_stage #(
   parameter int IN_W = 16,
   localparam int D_W = IN_W + 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic signed [IN_W-1:0] in_i,
   input  logic signed [IN_W-1:0] in_q,
   input  logic                   in_vld,
   input  logic signed [IN_W-1:0] dc_i,
   input  logic signed [IN_W-1:0] dc_q,
   output logic signed [D_W-1:0]  i_d,
   output logic signed [D_W-1:0]  q_d,
   output logic                   vld_d
);
   // One extra bit keeps the difference exact
   always_ff @(posedge clk) begin
      if (rst) begin
         i_d   <= '0;
         q_d   <= '0;
         vld_d <= 1'b0;
      end else begin
         i_d   <= D_W'(in_i) - D_W'(dc_i);
         q_d   <= D_W'(in_q) - D_W'(dc_q);
         vld_d <= in_vld;
      end
   end

   assert_vld_stage1_R2: assert property (@(posedge clk) disable iff (rst)
      vld_d == $past(in_vld));
endmodule

// File: rtl/rxiq_imbalance.sv
module rxiq_imbalance #(
   parameter int D_W    = 17,
   parameter int COEF_W = 18,
   parameter int OUT_W  = 24,
   parameter bit IMB_EN = 1'b1,
   localparam int FRAC  = COEF_W - 1,
   localparam int SH    = OUT_W - D_W,
   localparam int RSH   = FRAC - SH,
   localparam int P_W   = COEF_W + D_W,
   localparam int S_W   = P_W + 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [D_W-1:0]    i_d,
   input  logic signed [D_W-1:0]    q_d,
   input  logic                     vld_d,
   input  logic signed [COEF_W-1:0] mag,
   input  logic signed [COEF_W-1:0] phase,
   output logic signed [OUT_W-1:0]  out_i,
   output logic signed [OUT_W-1:0]  out_q,
   output logic                     out_vld
);
   if (SH < 0 || RSH < 0) begin : g_bad_scale
      $error("rxiq_imbalance: output width must fit the scaled difference");
   end

   logic signed [D_W-1:0] i2, q2;
   logic                  v2;

   always_ff @(posedge clk) begin
      if (rst) begin
         i2 <= '0;
         q2 <= '0;
         v2 <= 1'b0;
      end else begin
         i2 <= i_d;
         q2 <= q_d;
         v2 <= vld_d;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_i   <= '0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= v2;
         if (v2) out_i <= OUT_W'(i2) <<< SH;
      end
   end

   if (IMB_EN) begin : g_imb
      localparam logic signed [S_W-1:0] MAXV = S_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
      localparam logic signed [S_W-1:0] MINV = -MAXV - S_W'(1);

      logic signed [P_W-1:0] pm, pp;
      logic signed [S_W-1:0] sum, scaled;

      always_ff @(posedge clk) begin
         if (rst) begin
            pm <= '0;
            pp <= '0;
         end else begin
            pm <= P_W'(mag)   * P_W'(i_d);
            pp <= P_W'(phase) * P_W'(q_d);
         end
      end

      always_comb begin
         sum    = (S_W'(q2) <<< FRAC) + S_W'(pm) + S_W'(pp);
         scaled = sum >>> RSH;
      end

      always_ff @(posedge clk) begin
         if (rst) out_q <= '0;
         else if (v2) begin
            if (scaled > MAXV)      out_q <= MAXV[OUT_W-1:0];
            else if (scaled < MINV) out_q <= MINV[OUT_W-1:0];
            else                    out_q <= scaled[OUT_W-1:0];
         end
      end
   end else begin : g_bypass
      always_ff @(posedge clk) begin
         if (rst)     out_q <= '0;
         else if (v2) out_q <= OUT_W'(q2) <<< SH;
      end

      assert_q_bypass_R9: assert property (@(posedge clk) disable iff (rst)
         v2 |=> (out_q == (OUT_W'($past(q2)) <<< SH)));
   end

   assert_vld_pipe_R2: assert property (@(posedge clk) disable iff (rst)
      out_vld == $past(v2));

   assert_i_path_R3: assert property (@(posedge clk) disable iff (rst)
      v2 |=> (out_i == (OUT_W'($past(i2)) <<< SH)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !v2 |=> ($stable(out_i) && $stable(out_q)));
endmodule

// File: rtl/rx_iq_conditioner.sv
module rx_iq_conditioner #(
   parameter int         IN_W   = 16,
   parameter int         OUT_W  = 24,
   parameter int         COEF_W = 18,
   parameter bit         IMB_EN = 1'b1,
   parameter logic [7:0] BASE   = 8'h40,
   localparam int        D_W    = IN_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_stb,
   input  logic [7:0]        set_addr,
   input  logic [31:0]       set_data,
   input  logic [IN_W-1:0]   in_i,
   input  logic [IN_W-1:0]   in_q,
   input  logic              in_vld,
   output logic [OUT_W-1:0]  out_i,
   output logic [OUT_W-1:0]  out_q,
   output logic              out_vld
);
   if (BASE[1:0] != 2'b00) begin : g_bad_base
      $error("rx_iq_conditioner: BASE must be aligned to four registers");
   end

   logic signed [IN_W-1:0]   dc_i, dc_q;
   logic signed [COEF_W-1:0] mag, phase;
   logic signed [D_W-1:0]    i_d, q_d;
   logic                     vld_d;
   logic signed [OUT_W-1:0]  oi, oq;

   rxiq_settings #(.IN_W(IN_W), .COEF_W(COEF_W), .BASE(BASE)) u_set (
      .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr),
      .set_data(set_data), .dc_i(dc_i), .dc_q(dc_q), .mag(mag), .phase(phase));

   rxiq_dc_stage #(.IN_W(IN_W)) u_dc (
      .clk(clk), .rst(rst), .in_i(in_i), .in_q(in_q), .in_vld(in_vld),
      .dc_i(dc_i), .dc_q(dc_q), .i_d(i_d), .q_d(q_d), .vld_d(vld_d));

   rxiq_imbalance #(.D_W(D_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .IMB_EN(IMB_EN)) u_imb (
      .clk(clk), .rst(rst), .i_d(i_d), .q_d(q_d), .vld_d(vld_d),
      .mag(mag), .phase(phase), .out_i(oi), .out_q(oq), .out_vld(out_vld));

   assign out_i = oi;
   assign out_q = oq;
endmodule

// File: tb/rx_iq_conditioner_tb_top.sv
module rx_iq_conditioner_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        set_stb = 1'b0;
   logic [7:0]  set_addr = '0;
   logic [31:0] set_data = '0;
   logic [15:0] in_i = '0, in_q = '0;
   logic        in_vld = 1'b0;
   logic [23:0] out_i, out_q, nb_i, nb_q;
   logic        out_vld, nb_vld;

   always #2 clk = ~clk;

   rx_iq_conditioner dut_i (
      .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
      .in_i(in_i), .in_q(in_q), .in_vld(in_vld),
      .out_i(out_i), .out_q(out_q), .out_vld(out_vld));

   rx_iq_conditioner #(.IMB_EN(1'b0)) dut_noimb (
      .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
      .in_i(in_i), .in_q(in_q), .in_vld(in_vld),
      .out_i(nb_i), .out_q(nb_q), .out_vld(nb_vld));

   typedef struct {
      longint ei, eq, en;
      int     stamp;
      string  tag;
   } exp_t;

   exp_t   sb[$];
   int     tests = 0, fails = 0, cyc = 0;
   longint m_dci = 0, m_dcq = 0, m_mag = 0, m_ph = 0;
   logic [23:0] last_i = '0, last_q = '0;
   bit     done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Settings write with idle margin so no sample sees a half-applied update (R6)
   task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit stb);
      repeat (4) @(negedge clk);
      set_stb = stb; set_addr = a; set_data = d;
      @(negedge clk);
      set_stb = 1'b0;
      if (stb) case (a)
         8'h40: m_dci = longint'($signed(d[15:0]));
         8'h41: m_dcq = longint'($signed(d[15:0]));
         8'h42: m_mag = longint'($signed(d[17:0]));
         8'h43: m_ph  = longint'($signed(d[17:0]));
         default: ;
      endcase
      repeat (2) @(negedge clk);
   endtask

   task automatic send(input int i, input int q, input string tag);
      exp_t e;
      longint id, qd, s;
      @(negedge clk);
      in_i = 16'(i); in_q = 16'(q); in_vld = 1'b1;
      id = longint'(i) - m_dci;
      qd = longint'(q) - m_dcq;
      s  = (qd <<< 17) + m_mag * id + m_ph * qd;
      s  = s >>> 10;
      if (s > 8388607) s = 8388607;
      if (s < -8388608) s = -8388608;
      e.ei = id * 128; e.eq = s; e.en = qd * 128; e.stamp = cyc; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_vld = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_vld) begin
            if (sb.size() == 0) check(1'b0, "R2 unexpected out_vld", 1, 0);
            else begin
               exp_t e;
               e = sb.pop_front();
               check(cyc - e.stamp == 3, {e.tag, " R2 latency"}, cyc - e.stamp, 3);
               check(longint'($signed(out_i)) == e.ei, {e.tag, " R3 out_i"}, longint'($signed(out_i)), e.ei);
               check(longint'($signed(out_q)) == e.eq, {e.tag, " R4 out_q"}, longint'($signed(out_q)), e.eq);
               check(nb_vld && longint'($signed(nb_q)) == e.en, {e.tag, " R9 bypass out_q"}, longint'($signed(nb_q)), e.en);
            end
            last_i = out_i; last_q = out_q;
         end else begin
            check(out_i == last_i && out_q == last_q, "R8 hold while idle", longint'($signed(out_q)), longint'($signed(last_q)));
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog expired", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_vld == 1'b0, "R1 reset out_vld", out_vld, 0);
      check(out_i == '0, "R1 reset out_i", out_i, 0);
      check(out_q == '0, "R1 reset out_q", out_q, 0);
      rst = 1'b0;
      @(negedge clk);

      // R1: default settings pass scaled samples
      send(1000, -2000, "R1 default");
      send(-32768, 32767, "R1 default extreme");
      idle(5);

      // R3 / R6: offsets
      wr(8'h40, 32'h0000_0064, 1'b1);
      wr(8'h41, 32'hFFFF_FFCE, 1'b1);
      send(500, 500, "R6 dc");
      idle(2);
      send(-700, 1234, "R3 dc");
      idle(5);

      // R4 / R2: coefficients and a back-to-back burst
      wr(8'h42, 32'h0000_1000, 1'b1);
      wr(8'h43, 32'h0003_F830, 1'b1);
      for (int k = 0; k < 8; k++)
         send(k * 3917 - 15000, 12000 - k * 2711, "R4 burst");
      idle(6);

      // R5: clamp high and low
      wr(8'h40, 32'h0000_8000, 1'b1);
      wr(8'h41, 32'h0000_8000, 1'b1);
      wr(8'h42, 32'h0001_FFFF, 1'b1);
      wr(8'h43, 32'h0000_0000, 1'b1);
      send(32767, 32767, "R5 clamp high");
      idle(5);
      wr(8'h40, 32'h0000_7FFF, 1'b1);
      wr(8'h41, 32'h0000_7FFF, 1'b1);
      send(-32768, -32768, "R5 clamp low");
      idle(5);

      // R7: writes that must be ignored
      wr(8'h44, 32'h0000_1234, 1'b1);
      wr(8'h3F, 32'h0000_1234, 1'b1);
      wr(8'h40, 32'h0000_1234, 1'b0);
      wr(8'h42, 32'h0000_0000, 1'b0);
      send(100, -100, "R7 ignored writes");
      idle(6);

      check(sb.size() == 0, "R2 all results delivered", sb.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule